// File: doc/BRIEF.md
# Serial Flash Write Command Guard

This block decides whether a write-class command on a serial flash interface may be carried out. It oversamples chip select, serial clock and serial data with a reference clock. It captures the opcode from the first eight clocks of each selected frame, and counts whole bytes and the bit position within the current byte. The rising edge of chip select closes the frame. At that point the guard checks the frame against length and alignment rules for its opcode. It then emits either a one-clock commit strobe with the opcode, or a one-clock reject strobe. Frames that carry no write-class opcode pass through without any verdict.

Two lockout timers start counting when the supply-good input is seen high. Reads are allowed after a short window (100 µs by default). Writes are allowed after a long window (10 ms by default). Both windows are given in microseconds and converted to reference-clock cycles through a clock-frequency parameter. A write-class frame that closes before the write window has elapsed is rejected. When supply-good drops, both timers restart and any frame in progress is abandoned without a verdict. If chip select is already low when the supply becomes good, that frame is ignored.

The controller has five states:
- NO_SUPPLY: supply-good is absent.
- WAIT_DESEL: the supply is good but chip select is still low.
- IDLE: waiting for the next frame.
- FRAME: a frame is open.
- DECIDE: the frame has just closed.

Transitions:
- Any state goes to NO_SUPPLY on supply loss.
- NO_SUPPLY goes to IDLE or WAIT_DESEL depending on the chip-select level.
- WAIT_DESEL goes to IDLE once chip select is high.
- IDLE goes to FRAME on a chip-select fall.
- FRAME goes to DECIDE on a chip-select rise.
- DECIDE goes back to IDLE after one clock.

Top module: `write_cmd_guard`

## Requirements
- R1: While reset is asserted or supply-good is low, commit_o, reject_o, read_ok_o and write_ok_o are all low.
- R2: read_ok_o rises RD_LOCK_US·CLK_HZ/10^6 cycles (plus two cycles of synchronization) after supply-good is seen high, and stays low before that.
- R3: write_ok_o rises WR_LOCK_US·CLK_HZ/10^6 cycles after supply-good is seen high. A write-class frame that closes while write_ok_o is low is rejected. write_ok_o is never high while read_ok_o is low.
- R4: Loss of supply-good clears read_ok_o and write_ok_o within one cycle and restarts both timers. A frame open at that moment yields neither commit nor reject.
- R5: A write-class frame whose clock count at chip-select rise is not a multiple of 8 is rejected.
- R6: Page program (opcode 02h) commits only with at least 5 whole bytes: the opcode, 3 address bytes and at least one data byte. With fewer bytes it is rejected.
- R7: Status write (opcode 01h) commits only with exactly 2 bytes. Frames of 1 byte, or of 3 or more bytes, are rejected.
- R8: Sector erase (opcode 20h) commits only with exactly 4 bytes. Chip erase (C7h) and write enable (06h) commit only with exactly 1 byte.
- R9: Frames with any other opcode, and frames of fewer than 8 clocks, produce neither commit nor reject.
- R10: commit_o and reject_o are single-cycle pulses and are never high together. commit_op_o shows the committed opcode while commit_o is high.
- R11: A frame during which supply-good became valid while chip select was already low is ignored. The next frame after deselection is judged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_good_i | input | 1 | Supply has reached its valid level |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, MSB first |
| commit_o | output | 1 | One-cycle strobe: write command accepted |
| reject_o | output | 1 | One-cycle strobe: write command refused |
| commit_op_o | output | 8 | Opcode of the last committed command |
| read_ok_o | output | 1 | Read lockout window has elapsed |
| write_ok_o | output | 1 | Write lockout window has elapsed |

## Verification
The hardest situations to reach are the ones that depend on the supply history rather than on frame contents. Examples are a frame interrupted by supply loss, and a frame already open when the supply comes up. The bench reaches them by holding chip select low with supply-good deasserted, then raising supply-good in the middle of the frame. In the other case it drops supply-good after clocking a frame that would otherwise commit. While write_ok_o is still low, the expected outcome of an ignored frame (no strobe) differs from a judged one (reject), so the two cases can be told apart. Lockout edges are sampled at fixed cycle offsets on either side of the computed window.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

    typedef enum logic [2:0] {
        ST_NO_SUPPLY,
        ST_WAIT_DESEL,
        ST_IDLE,
        ST_FRAME,
        ST_DECIDE
    } guard_state_t;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_SINGLE,
        CLS_STATUS,
        CLS_PROG,
        CLS_SECTOR
    } wr_class_t;

    localparam logic [7:0] OPC_WREN       = 8'h06;
    localparam logic [7:0] OPC_STATUS_WR  = 8'h01;
    localparam logic [7:0] OPC_PAGE_PROG  = 8'h02;
    localparam logic [7:0] OPC_SECT_ERASE = 8'h20;
    localparam logic [7:0] OPC_CHIP_ERASE = 8'hC7;

    localparam int PROG_MIN_BYTES   = 5;
    localparam int STATUS_BYTES     = 2;
    localparam int SECTOR_BYTES     = 4;
    localparam int SINGLE_BYTES     = 1;

    function automatic wr_class_t classify(input logic [7:0] op);
        wr_class_t c;
        unique case (op)
            OPC_WREN, OPC_CHIP_ERASE: c = CLS_SINGLE;
            OPC_STATUS_WR:            c = CLS_STATUS;
            OPC_PAGE_PROG:            c = CLS_PROG;
            OPC_SECT_ERASE:           c = CLS_SECTOR;
            default:                  c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wcg_lock_timer.sv
module wcg_lock_timer #(
    parameter longint unsigned LIMIT = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LIM);
endmodule

// File: rtl/wcg_frame_tracker.sv
module wcg_frame_tracker #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              cs_ni,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              cs_high_o,
    output logic              frame_start_o,
    output logic              frame_end_o,
    output logic [7:0]        opcode_o,
    output logic [2:0]        bit_phase_o,
    output logic [BYTE_W-1:0] byte_cnt_o
);
    localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
    localparam logic [2:0] PIPE_RST = 3'b100;   // cs high, sck low, sdi low

    logic [2:0] pipe_q [SYNC_STAGES];
    logic [2:0] prev_q;
    logic [2:0] cur;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= PIPE_RST;
            prev_q <= PIPE_RST;
        end else begin
            pipe_q[0] <= {cs_ni, sck_i, sdi_i};
            for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            prev_q <= pipe_q[SYNC_STAGES-1];
        end
    end

    assign cur = pipe_q[SYNC_STAGES-1];

    logic sck_rise;
    assign cs_high_o     = cur[2];
    assign frame_start_o = prev_q[2] && !cur[2];
    assign frame_end_o   = !prev_q[2] && cur[2];
    assign sck_rise      = !cur[2] && !prev_q[1] && cur[1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            opcode_o    <= '0;
            bit_phase_o <= '0;
            byte_cnt_o  <= '0;
        end else if (clear_i || frame_start_o) begin
            opcode_o    <= '0;
            bit_phase_o <= '0;
            byte_cnt_o  <= '0;
        end else if (sck_rise) begin
            if (byte_cnt_o == '0) opcode_o <= {opcode_o[6:0], cur[0]};
            bit_phase_o <= bit_phase_o + 3'd1;
            if (bit_phase_o == 3'd7 && byte_cnt_o != BYTE_MAX)
                byte_cnt_o <= byte_cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/wcg_rule_check.sv
module wcg_rule_check
    import wcg_pkg::*;
#(
    parameter int BYTE_W = 4
) (
    input  logic [7:0]        opcode_i,
    input  logic [2:0]        bit_phase_i,
    input  logic [BYTE_W-1:0] byte_cnt_i,
    output logic              is_write_o,
    output logic              shape_ok_o
);
    wr_class_t cls;
    logic      len_ok;
    logic      aligned;

    assign cls        = (byte_cnt_i == '0) ? CLS_NONE : classify(opcode_i);
    assign is_write_o = (cls != CLS_NONE);
    assign aligned    = (bit_phase_i == 3'd0);

    always_comb begin
        unique case (cls)
            CLS_SINGLE: len_ok = (byte_cnt_i == BYTE_W'(SINGLE_BYTES));
            CLS_STATUS: len_ok = (byte_cnt_i == BYTE_W'(STATUS_BYTES));
            CLS_PROG:   len_ok = (byte_cnt_i >= BYTE_W'(PROG_MIN_BYTES));
            CLS_SECTOR: len_ok = (byte_cnt_i == BYTE_W'(SECTOR_BYTES));
            default:    len_ok = 1'b0;
        endcase
    end

    assign shape_ok_o = aligned && len_ok;
endmodule

// File: rtl/write_cmd_guard.sv
module write_cmd_guard
    import wcg_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 100_000_000,
    parameter longint unsigned RD_LOCK_US  = 100,
    parameter longint unsigned WR_LOCK_US  = 10_000,
    parameter int              SYNC_STAGES = 2,
    parameter int              BYTE_W      = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_good_i,
    input  logic       cs_ni,
    input  logic       sck_i,
    input  logic       sdi_i,
    output logic       commit_o,
    output logic       reject_o,
    output logic [7:0] commit_op_o,
    output logic       read_ok_o,
    output logic       write_ok_o
);
    localparam longint unsigned RD_CYCLES = (CLK_HZ * RD_LOCK_US) / 64'd1_000_000;
    localparam longint unsigned WR_CYCLES = (CLK_HZ * WR_LOCK_US) / 64'd1_000_000;
    localparam int NUM_TIMERS = 2;

    // supply-good synchronizer
    logic [SYNC_STAGES-1:0] sup_pipe_q;
    logic                   sup_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sup_pipe_q <= '0;
        else         sup_pipe_q <= {sup_pipe_q[SYNC_STAGES-2:0], supply_good_i};
    end
    assign sup_s = sup_pipe_q[SYNC_STAGES-1];

    // lockout timers: index 0 read, index 1 write
    logic [NUM_TIMERS-1:0] lock_done;

    for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_timer
        wcg_lock_timer #(
            .LIMIT((gi == 0) ? RD_CYCLES : WR_CYCLES)
        ) timer_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .run_i (sup_s),
            .done_o(lock_done[gi])
        );
    end

    assign read_ok_o  = lock_done[0];
    assign write_ok_o = lock_done[1];

    // frame tracking
    logic              cs_high;
    logic              frame_start;
    logic              frame_end;
    logic [7:0]        opcode;
    logic [2:0]        bit_phase;
    logic [BYTE_W-1:0] byte_cnt;

    wcg_frame_tracker #(
        .SYNC_STAGES(SYNC_STAGES),
        .BYTE_W     (BYTE_W)
    ) tracker_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clear_i      (!sup_s),
        .cs_ni        (cs_ni),
        .sck_i        (sck_i),
        .sdi_i        (sdi_i),
        .cs_high_o    (cs_high),
        .frame_start_o(frame_start),
        .frame_end_o  (frame_end),
        .opcode_o     (opcode),
        .bit_phase_o  (bit_phase),
        .byte_cnt_o   (byte_cnt)
    );

    logic is_write;
    logic shape_ok;

    wcg_rule_check #(
        .BYTE_W(BYTE_W)
    ) rules_i (
        .opcode_i   (opcode),
        .bit_phase_i(bit_phase),
        .byte_cnt_i (byte_cnt),
        .is_write_o (is_write),
        .shape_ok_o (shape_ok)
    );

    // controller
    guard_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!sup_s) begin
            state_d = ST_NO_SUPPLY;
        end else begin
            unique case (state_q)
                ST_NO_SUPPLY:  state_d = cs_high ? ST_IDLE : ST_WAIT_DESEL;
                ST_WAIT_DESEL: if (cs_high) state_d = ST_IDLE;
                ST_IDLE:       if (frame_start) state_d = ST_FRAME;
                ST_FRAME:      if (frame_end) state_d = ST_DECIDE;
                ST_DECIDE:     state_d = ST_IDLE;
                default:       state_d = ST_NO_SUPPLY;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_NO_SUPPLY;
        else         state_q <= state_d;
    end

    // verdict outputs
    logic judge;
    assign judge = (state_q == ST_DECIDE) && sup_s && is_write;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            commit_o    <= 1'b0;
            reject_o    <= 1'b0;
            commit_op_o <= '0;
        end else begin
            commit_o <= judge && shape_ok && write_ok_o;
            reject_o <= judge && !(shape_ok && write_ok_o);
            if (judge && shape_ok && write_ok_o) commit_op_o <= opcode;
        end
    end
endmodule

// File: rtl/wcg_guard_chk.sv
module wcg_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sup_s,
    input logic commit_o,
    input logic reject_o,
    input logic read_ok_o,
    input logic write_ok_o
);
    // R10
    verdict_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(commit_o && reject_o));

    // R10
    commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |=> !commit_o);

    // R10
    reject_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reject_o |=> !reject_o);

    // R3
    commit_after_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> $past(write_ok_o));

    // R3
    lockout_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        write_ok_o |-> read_ok_o);

    // R4
    supply_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sup_s |=> (!read_ok_o && !write_ok_o && !commit_o && !reject_o));
endmodule

bind write_cmd_guard wcg_guard_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sup_s     (sup_s),
    .commit_o  (commit_o),
    .reject_o  (reject_o),
    .read_ok_o (read_ok_o),
    .write_ok_o(write_ok_o)
);

// File: tb/write_cmd_guard_tb_top.sv
module write_cmd_guard_tb_top;

    localparam longint unsigned TB_CLK_HZ = 1_000_000;  // 100 read cycles, 10000 write cycles
    localparam int RD_WIN = 100;
    localparam int WR_WIN = 10000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_good = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       commit;
    logic       reject;
    logic [7:0] commit_op;
    logic       read_ok;
    logic       write_ok;

    always #5 clk = ~clk;

    write_cmd_guard #(
        .CLK_HZ(TB_CLK_HZ)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .supply_good_i(supply_good),
        .cs_ni        (cs_n),
        .sck_i        (sck),
        .sdi_i        (sdi),
        .commit_o     (commit),
        .reject_o     (reject),
        .commit_op_o  (commit_op),
        .read_ok_o    (read_ok),
        .write_ok_o   (write_ok)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_commit = 0;
    int n_reject = 0;
    logic [7:0] last_op = '0;
    bit both_seen = 0;
    bit wide_seen = 0;
    logic prev_commit = 0;
    logic prev_reject = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (commit) begin
            n_commit++;
            last_op = commit_op;
        end
        if (reject) n_reject++;
        if (commit && reject) both_seen = 1;
        if ((commit && prev_commit) || (reject && prev_reject)) wide_seen = 1;
        prev_commit = commit;
        prev_reject = reject;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clock_bits(input logic [7:0] op, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? op[7-i] : i[0];
            sck = 1'b0;
            tick(2);
            sck = 1'b1;
            tick(3);
            sck = 1'b0;
            tick(1);
        end
    endtask

    task automatic send_frame(input logic [7:0] op, input int nbits);
        cs_n = 1'b0;
        tick(4);
        clock_bits(op, nbits);
        tick(4);
        cs_n = 1'b1;
        tick(12);
    endtask

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] nbits;
        logic       cm;
        logic       rj;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'h02, 8'd40, 1'b1, 1'b0, 4'd6},  // R6 minimum program
        '{8'h02, 8'd32, 1'b0, 1'b1, 4'd6},  // R6 no data byte
        '{8'h02, 8'd44, 1'b0, 1'b1, 4'd5},  // R5 partial trailing byte
        '{8'h02, 8'd64, 1'b1, 1'b0, 4'd6},  // R6 longer program
        '{8'h01, 8'd16, 1'b1, 1'b0, 4'd7},  // R7 exact status write
        '{8'h01, 8'd24, 1'b0, 1'b1, 4'd7},  // R7 two data bytes
        '{8'h01, 8'd8,  1'b0, 1'b1, 4'd7},  // R7 no data byte
        '{8'h20, 8'd32, 1'b1, 1'b0, 4'd8},  // R8 sector erase
        '{8'h20, 8'd40, 1'b0, 1'b1, 4'd8},  // R8 sector erase too long
        '{8'hC7, 8'd8,  1'b1, 1'b0, 4'd8},  // R8 chip erase
        '{8'hC7, 8'd16, 1'b0, 1'b1, 4'd8},  // R8 chip erase too long
        '{8'h06, 8'd8,  1'b1, 1'b0, 4'd8},  // R8 write enable
        '{8'h06, 8'd12, 1'b0, 1'b1, 4'd5},  // R5 misaligned
        '{8'h03, 8'd40, 1'b0, 1'b0, 4'd9},  // R9 read opcode
        '{8'h02, 8'd5,  1'b0, 1'b0, 4'd9},  // R9 short frame
        '{8'h9F, 8'd8,  1'b0, 1'b0, 4'd9}   // R9 other opcode
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0;
        int c0;
        int r0;
        string rq;

        // R1 reset state
        tick(3);
        check(!commit && !reject && !read_ok && !write_ok, "R1", "outputs in reset",
              {commit, reject, read_ok, write_ok}, 0);
        rst_n = 1'b1;
        tick(5);
        check(!read_ok && !write_ok, "R1", "outputs without supply", {read_ok, write_ok}, 0);

        // R2 read window
        supply_good = 1'b1;
        t0 = cyc;
        while (cyc < t0 + RD_WIN - 10) tick(1);
        check(!read_ok, "R2", "read_ok before window", read_ok, 0);
        while (cyc < t0 + RD_WIN + 15) tick(1);
        check(read_ok, "R2", "read_ok after window", read_ok, 1);

        // R3 write during lockout rejected
        c0 = n_commit; r0 = n_reject;
        send_frame(8'h06, 8);
        check(n_reject - r0 == 1 && n_commit == c0, "R3", "reject during lockout",
              n_reject - r0, 1);

        while (cyc < t0 + WR_WIN - 50) tick(1);
        check(!write_ok, "R3", "write_ok before window", write_ok, 0);
        while (cyc < t0 + WR_WIN + 50) tick(1);
        check(write_ok, "R3", "write_ok after window", write_ok, 1);

        // table of frame vectors
        for (int v = 0; v < NV; v++) begin
            c0 = n_commit; r0 = n_reject;
            send_frame(VECS[v].op, int'(VECS[v].nbits));
            rq = $sformatf("R%0d", VECS[v].req);
            check(n_commit - c0 == int'(VECS[v].cm), rq,
                  $sformatf("commit count vec %0d", v), n_commit - c0, VECS[v].cm);
            check(n_reject - r0 == int'(VECS[v].rj), rq,
                  $sformatf("reject count vec %0d", v), n_reject - r0, VECS[v].rj);
            if (VECS[v].cm)
                check(last_op == VECS[v].op, "R10", "committed opcode", last_op, VECS[v].op);
        end

        // R10 pulse shape
        check(!both_seen, "R10", "commit and reject together", both_seen, 0);
        check(!wide_seen, "R10", "strobe wider than one cycle", wide_seen, 0);

        // R4 supply loss during an open frame
        c0 = n_commit; r0 = n_reject;
        cs_n = 1'b0;
        tick(4);
        clock_bits(8'h06, 8);
        supply_good = 1'b0;
        tick(20);
        cs_n = 1'b1;
        tick(20);
        check(n_commit == c0 && n_reject == r0, "R4", "verdict after supply loss",
              (n_commit - c0) + (n_reject - r0), 0);
        check(!read_ok && !write_ok, "R4", "status after supply loss", {read_ok, write_ok}, 0);

        // R11 supply arrives while selected: frame ignored (would otherwise be rejected)
        cs_n = 1'b0;
        tick(4);
        supply_good = 1'b1;
        t0 = cyc;
        tick(4);
        clock_bits(8'h06, 8);
        tick(4);
        cs_n = 1'b1;
        tick(12);
        check(n_commit == c0 && n_reject == r0, "R11", "frame open at supply-good ignored",
              (n_commit - c0) + (n_reject - r0), 0);

        // R4 timers restarted
        while (cyc < t0 + RD_WIN + 20) tick(1);
        check(read_ok && !write_ok, "R4", "timers restarted", {read_ok, write_ok}, 2);

        // R11 next frame judged normally (still in write lockout)
        send_frame(8'h06, 8);
        check(n_reject - r0 == 1 && n_commit == c0, "R11", "frame after deselect judged",
              n_reject - r0, 1);

        finish_run();
    end

endmodule